// File: doc/BRIEF.md
# DRAM Parallel-Test Compression Model

This block is a cycle-based behavioural model of a small four-bit-wide dynamic memory that contains a built-in parallel-test compression mode. It is meant to sit on the device side of a memory controller's bench, so that the controller's test-mode sequencing can be checked. The model samples the active-low row strobe, column strobe and write strobe on a fast clock. It finds each edge by comparing a strobe with the value it had at the previous sample. Array depth is set by parameters, and the model has no analog timing.

In normal mode a row is opened on the row-strobe falling edge. Each column-strobe falling edge then reads or writes one four-bit word in that row, and several column accesses may follow one another while the row stays open. When the row strobe falls while both the column strobe and the write strobe are already low, the model enters test mode. In test mode the two lowest column bits are ignored. A write copies each data bit into the four cells of its group. A read returns, for each data bit, whether those four cells hold the same value. Test mode ends with a column-before-row cycle that has the write strobe high, or with a row-only cycle that sees no column access.

Top module: `dram_tc_model`

## Requirements
- R1: After reset, `test_mode_o` is 0, `dq_oe_o` is 0 and every cell holds 0.
- R2: In normal mode, a column-strobe fall with `we_ni` low inside an open row writes `dq_i` to the word at (row, column). `dq_oe_o` stays 0 during that access.
- R3: In normal mode, a column-strobe fall with `we_ni` high inside an open row sets `dq_oe_o` to 1 and drives the stored word on `dq_o`. Both are due one clock after the sampled edge.
- R4: A row-strobe fall sampled while `cas_ni` and `we_ni` are both low sets `test_mode_o` to 1 and performs no access.
- R5: A row-strobe fall sampled with `cas_ni` low and `we_ni` high clears `test_mode_o`. A row-strobe rise that ends a row in which no column-strobe fall occurred also clears `test_mode_o`.
- R6: In test mode, column bits [1:0] are ignored, and a write stores `dq_i` into all four words whose column differs only in those bits.
- R7: In a test-mode read, bit b of `dq_o` is 1 when bit b is equal in all four words of the addressed group, and 0 otherwise.
- R8: If `we_ni` falls during a read access while `cas_ni` is still low, the model writes `dq_i` to the accessed location, following the mode's rules, and `dq_oe_o` drops to 0.
- R9: A column-strobe rise or a row-strobe rise returns `dq_oe_o` to 0. `test_mode_o` changes only at a sampled row-strobe edge.
- R10: Several column accesses within one open row all use the row that was latched at the row-strobe fall.
- R11: A row-strobe fall with `cas_ni` and `we_ni` low while already in test mode keeps test mode set and alters no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| addr_i | input | ADDR_W | Row address at row-strobe fall; column address at column-strobe fall |
| dq_i | input | 4 | Write data |
| dq_o | output | 4 | Read data, or per-bit agreement flags in test mode |
| dq_oe_o | output | 1 | High while `dq_o` is driven; low means high impedance |
| test_mode_o | output | 1 | High while test compression mode is active |

## Verification
Each result is registered in the sample at which its strobe edge is first seen. This applies to mode changes, output enable, read data and writes, so every result is due one clock after the edge. The bench changes inputs on the falling clock edge and checks outputs on the next falling edge, half a cycle after the rising edge that registered them. A write is confirmed through a later read access, which again shows its data one clock after its column-strobe fall. Mode changes are read from `test_mode_o` at the end of each entry or exit sequence.

// File: rtl/dram_tc_pkg.sv
package dram_tc_pkg;
  localparam int unsigned DQ_W     = 4;
  localparam int unsigned GRP_BITS = 2;
  localparam int unsigned GRP_N    = 1 << GRP_BITS;

  localparam int unsigned STB_RAS = 0;
  localparam int unsigned STB_CAS = 1;
  localparam int unsigned STB_WE  = 2;
  localparam int unsigned STB_N   = 3;

  typedef logic [DQ_W-1:0] dq_t;

  // per-bit flag: 1 when all four lanes carry the same value
  function automatic dq_t lanes_agree(input dq_t a, input dq_t b, input dq_t c, input dq_t d);
    return ~((a ^ b) | (a ^ c) | (a ^ d));
  endfunction
endpackage

// File: rtl/dram_tc_edge.sv
module dram_tc_edge #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] stb_ni,
  output logic [N-1:0] fall_o,
  output logic [N-1:0] rise_o
);
  logic [N-1:0] prev_q;

  // strobes idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '1;
    else         prev_q <= stb_ni;
  end

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign fall_o[i] =  prev_q[i] & ~stb_ni[i];
    assign rise_o[i] = ~prev_q[i] &  stb_ni[i];
  end
endmodule

// File: rtl/dram_tc_array.sv
module dram_tc_array
  import dram_tc_pkg::*;
#(
  parameter int unsigned ROW_W = 3,
  parameter int unsigned COL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             test_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [COL_W-1:0] col_i,
  input  dq_t              wdata_i,
  output dq_t              rdata_o
);
  localparam int unsigned IDX_W = ROW_W + COL_W;
  localparam int unsigned WORDS = 1 << IDX_W;
  localparam int unsigned GCOL_W = COL_W - GRP_BITS;

  dq_t mem_q [WORDS];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    localparam logic [IDX_W-1:0] WIDX = IDX_W'(w);
    logic hit;
    always_comb begin
      if (test_i)
        hit = (WIDX[IDX_W-1:COL_W] == row_i) &&
              (WIDX[COL_W-1:GRP_BITS] == col_i[COL_W-1:GRP_BITS]);
      else
        hit = (WIDX == {row_i, col_i});
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)               mem_q[w] <= '0;
      else if (wr_en_i && hit)   mem_q[w] <= wdata_i;
    end
  end

  dq_t grp [GRP_N];
  for (genvar k = 0; k < GRP_N; k++) begin : g_lane
    assign grp[k] = mem_q[{row_i, col_i[COL_W-1:GRP_BITS], GRP_BITS'(k)}];
  end

  logic [GCOL_W-1:0] unused_gcol;
  assign unused_gcol = '0;

  assign rdata_o = test_i ? lanes_agree(grp[0], grp[1], grp[2], grp[3])
                          : mem_q[{row_i, col_i}];
endmodule

// File: rtl/dram_tc_ctrl.sv
module dram_tc_ctrl
  import dram_tc_pkg::*;
#(
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_fall_i,
  input  logic              ras_rise_i,
  input  logic              cas_fall_i,
  input  logic              cas_rise_i,
  input  logic              we_fall_i,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  dq_t               rd_word_i,
  output logic              wr_en_o,
  output logic [ROW_W-1:0]  row_o,
  output logic [COL_W-1:0]  col_o,
  output logic              test_o,
  output dq_t               dq_o,
  output logic              dq_oe_o
);
  logic             row_open_q, cas_used_q, acc_q, test_q, oe_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  dq_t              dq_q;
  logic             col_hit, early_wr, late_wr;

  assign col_hit  = cas_fall_i && row_open_q;
  assign early_wr = col_hit && !we_ni;
  // write strobe falling inside a read access: read-modify-write
  assign late_wr  = we_fall_i && acc_q && !cas_ni && !cas_fall_i;

  assign wr_en_o = early_wr || late_wr;
  assign row_o   = row_q;
  assign col_o   = cas_fall_i ? addr_i[COL_W-1:0] : col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_open_q <= 1'b0;
      cas_used_q <= 1'b0;
      acc_q      <= 1'b0;
      test_q     <= 1'b0;
      oe_q       <= 1'b0;
      row_q      <= '0;
      col_q      <= '0;
      dq_q       <= '0;
    end else begin
      if (ras_fall_i) begin
        if (!cas_ni) begin
          test_q     <= !we_ni;
          row_open_q <= 1'b0;
        end else begin
          row_open_q <= 1'b1;
          cas_used_q <= 1'b0;
          row_q      <= addr_i[ROW_W-1:0];
        end
      end else if (ras_rise_i) begin
        if (row_open_q && !cas_used_q) test_q <= 1'b0;
        row_open_q <= 1'b0;
        acc_q      <= 1'b0;
        oe_q       <= 1'b0;
      end else if (col_hit) begin
        cas_used_q <= 1'b1;
        acc_q      <= 1'b1;
        col_q      <= addr_i[COL_W-1:0];
        oe_q       <= we_ni;
        if (we_ni) dq_q <= rd_word_i;
      end else if (cas_rise_i) begin
        acc_q <= 1'b0;
        oe_q  <= 1'b0;
      end else if (late_wr) begin
        oe_q <= 1'b0;
      end
    end
  end

  assign test_o  = test_q;
  assign dq_o    = dq_q;
  assign dq_oe_o = oe_q;
endmodule

// File: rtl/dram_tc_model.sv
module dram_tc_model
  import dram_tc_pkg::*;
#(
  parameter int unsigned ROW_W  = 3,
  parameter int unsigned COL_W  = 4,
  parameter int unsigned ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [3:0]        dq_i,
  output logic [3:0]        dq_o,
  output logic              dq_oe_o,
  output logic              test_mode_o
);
  logic [STB_N-1:0] stb_fall, stb_rise;
  logic             ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic             unused_we_rise;
  logic             wr_en, test_mode;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  dq_t              rd_word;

  dram_tc_edge #(.N(STB_N)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stb_ni ({we_ni, cas_ni, ras_ni}),
    .fall_o (stb_fall),
    .rise_o (stb_rise)
  );

  assign ras_fall       = stb_fall[STB_RAS];
  assign ras_rise       = stb_rise[STB_RAS];
  assign cas_fall       = stb_fall[STB_CAS];
  assign cas_rise       = stb_rise[STB_CAS];
  assign we_fall        = stb_fall[STB_WE];
  assign unused_we_rise = stb_rise[STB_WE];

  dram_tc_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ras_fall_i (ras_fall),
    .ras_rise_i (ras_rise),
    .cas_fall_i (cas_fall),
    .cas_rise_i (cas_rise),
    .we_fall_i  (we_fall),
    .cas_ni     (cas_ni),
    .we_ni      (we_ni),
    .addr_i     (addr_i),
    .rd_word_i  (rd_word),
    .wr_en_o    (wr_en),
    .row_o      (row),
    .col_o      (col),
    .test_o     (test_mode),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );

  dram_tc_array #(.ROW_W(ROW_W), .COL_W(COL_W)) u_array (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .test_i  (test_mode),
    .row_i   (row),
    .col_i   (col),
    .wdata_i (dq_i),
    .rdata_o (rd_word)
  );

  assign test_mode_o = test_mode;
endmodule

// File: rtl/dram_tc_checker.sv
module dram_tc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_fall_i,
  input logic ras_rise_i,
  input logic cas_rise_i,
  input logic cas_ni,
  input logic we_ni,
  input logic test_mode_i,
  input logic dq_oe_i
);
  a_r4_wcbr_enters: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_fall_i && !cas_ni && !we_ni |=> test_mode_i);

  a_r5_cbr_exits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ras_fall_i && !cas_ni && we_ni |=> !test_mode_i);

  a_r9_mode_only_at_ras_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_fall_i && !ras_rise_i |=> $stable(test_mode_i));

  a_r9_oe_drops_on_cas_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cas_rise_i |=> !dq_oe_i);

  a_r3_oe_within_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_i |-> !$past(cas_ni));
endmodule

bind dram_tc_model dram_tc_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ras_fall_i  (ras_fall),
  .ras_rise_i  (ras_rise),
  .cas_rise_i  (cas_rise),
  .cas_ni      (cas_ni),
  .we_ni       (we_ni),
  .test_mode_i (test_mode),
  .dq_oe_i     (dq_oe_o)
);

// File: tb/sim_dram_tc_model.sv
`timescale 1ns/1ps
module sim_dram_tc_model;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [3:0] addr = '0;
  logic [3:0] dq_in = '0;
  logic [3:0] dq_out;
  logic       dq_oe, tmode;
  int         checks = 0, failures = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  dram_tc_model u0 (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .addr_i(addr), .dq_i(dq_in), .dq_o(dq_out), .dq_oe_o(dq_oe), .test_mode_o(tmode)
  );

  // op codes: 1 open row, 2 write, 3 read, 4 close row, 5 entry cycle, 6 exit cycle, 7 mode check
  localparam int NV = 23;
  localparam logic [15:0] VEC [NV] = '{
    16'h1200, 16'h205A, 16'h2063, 16'h305A, 16'h3063, 16'h4000, 16'h7000,
    16'h5000, 16'h7001,
    16'h1200, 16'h3044, 16'h2096, 16'h308F, 16'h30AF, 16'h4000,
    16'h5000, 16'h7001, 16'h6000, 16'h7000,
    16'h1200, 16'h3086, 16'h30B6, 16'h305A
  };

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic open_row(input logic [3:0] r);
    addr = r; ras_n = 1'b0; @(negedge clk);
  endtask
  task automatic close_row();
    ras_n = 1'b1; @(negedge clk); @(negedge clk);
  endtask
  task automatic wr(input logic [3:0] c, input logic [3:0] d, input string req);
    addr = c; dq_in = d; we_n = 1'b0; cas_n = 1'b0; @(negedge clk);
    chk(req, {3'b0, dq_oe}, 4'h0);
    cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
  endtask
  task automatic rd(input logic [3:0] c, input logic [3:0] e, input string req);
    addr = c; we_n = 1'b1; cas_n = 1'b0; @(negedge clk);
    chk({req, " oe"}, {3'b0, dq_oe}, 4'h1);
    chk(req, dq_out, e);
    cas_n = 1'b1; @(negedge clk);
    chk("R9 oe off after cas rise", {3'b0, dq_oe}, 4'h0);
  endtask
  task automatic cbr(input logic w);
    cas_n = 1'b0; we_n = w; @(negedge clk);
    ras_n = 1'b0; @(negedge clk);
    ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mode after reset", {3'b0, tmode}, 4'h0);
    chk("R1 oe after reset", {3'b0, dq_oe}, 4'h0);
    rst_n = 1'b1;
    @(negedge clk);
    open_row(4'h0);
    rd(4'h0, 4'h0, "R1 cell zero after reset");
    close_row();

    // table: R2 R3 R10 write/read in page, R4 entry, R7 R6 compression, R11 refresh in test, R5 exit
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, a, d, e;
      {op, a, d, e} = VEC[i];
      case (op)
        4'h1: open_row(a);
        4'h2: wr(d, e, "R2 write oe");
        4'h3: rd(d, e, "R3 R7 R10 R6 read data");
        4'h4: close_row();
        4'h5: cbr(1'b0);
        4'h6: cbr(1'b1);
        default: chk("R4 R5 R11 mode flag", {3'b0, tmode}, e);
      endcase
    end
    close_row();

    // R5: row-only cycle leaves test mode
    cbr(1'b0);
    chk("R4 entry before row-only", {3'b0, tmode}, 4'h1);
    open_row(4'h3);
    close_row();
    chk("R5 row-only exit", {3'b0, tmode}, 4'h0);

    // R8: late write during a read access
    open_row(4'h1);
    addr = 4'h3; we_n = 1'b1; cas_n = 1'b0; @(negedge clk);
    chk("R8 read before late write", dq_out, 4'h0);
    dq_in = 4'h9; we_n = 1'b0; @(negedge clk);
    chk("R8 oe drops on late write", {3'b0, dq_oe}, 4'h0);
    cas_n = 1'b1; we_n = 1'b1; @(negedge clk);
    rd(4'h3, 4'h9, "R8 late write stored");
    close_row();

    // R9: row-strobe rise with column strobe held low drops output enable
    open_row(4'h1);
    addr = 4'h3; cas_n = 1'b0; @(negedge clk);
    ras_n = 1'b1; @(negedge clk);
    chk("R9 oe off after ras rise", {3'b0, dq_oe}, 4'h0);
    cas_n = 1'b1; @(negedge clk); @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule